// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing half of a small serial EEPROM. It watches a two-wire bus (SCL and SDA, oversampled by the system clock), finds START and STOP conditions, and decodes each transfer: a select byte carrying the device address and a direction bit, then a word address, then data. It acknowledges by pulling SDA low through an open-drain enable, and it shifts read data out most significant bit first.

On the memory side it presents each accepted write byte to a page buffer as a one-cycle strobe with address and data. It pulses a commit line when a STOP closes a write, and it asks for read bytes with a one-cycle request whose data the memory returns one clock later. While the memory reports a write cycle in progress, the controller stays silent on its own select byte. A host can therefore poll for completion. A write-protect input lets the address phase through but refuses the first data byte.

Within a page write, only the low address bits advance, so a burst that runs past the page end wraps back to the page start. Reads advance the full address and roll over from the top of the array to zero.

Top module: `ee2w_slave`

## Requirements
- R1: After reset, sda_oe, wr_stb, commit and rd_req are all low.
- R2: A select byte whose upper seven bits equal DEV_ADDR (default 7'h50, so 8'hA0 writes and 8'hA1 reads) is acknowledged. Any other select byte gets no acknowledge, and later bytes are ignored until the next START.
- R3: In a write, the byte after the select byte loads the address counter. Each further byte is acknowledged and emitted on wr_stb with the current address. The counter then increments only its low PAGE_W bits (default 3), wrapping inside the page while the upper bits stay unchanged.
- R4: A STOP after at least one accepted data byte pulses commit for exactly one cycle. A STOP with no accepted data byte produces no commit.
- R5: While busy_in is high, a matching select byte is not acknowledged. Once busy_in is low again, it is acknowledged.
- R6: With wp_in high, the select and word-address bytes are acknowledged. The first data byte is not acknowledged, nothing is strobed, no commit follows, and memory content is unchanged.
- R7: A read returns the byte at the address counter, MSB first, and then advances the full counter, rolling over from the highest address to 0. A read not preceded by a word address continues from the current counter. rd_data is taken one cycle after rd_req.
- R8: A master NACK after a read byte releases SDA and returns the controller to idle, so it acknowledges nothing until the next START.
- R9: A repeated START restarts select-byte decoding, so a word-address write followed by a repeated START and a read select returns data from that word address.
- R10: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wp_in | input | 1 | Write protect, 1 blocks data bytes |
| busy_in | input | 1 | Internal write cycle in progress |
| wr_stb | output | 1 | One-cycle write byte strobe to page buffer |
| wr_addr | output | ADDR_W | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit | output | 1 | One-cycle request to program the staged page |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Address of the requested byte |
| rd_data | input | 8 | Read byte, valid the cycle after rd_req |

## Verification
Two events land close together: the commit raised by a STOP, and the decision on the next select byte, which reads busy_in. The bench's memory model raises busy the clock after commit. The bench then issues START and a select byte at once, with no idle gap. It expects the missing acknowledge on that byte and an acknowledge only after busy has dropped. The second, data-free transaction must also leave the commit count unchanged.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } bus_st_e;

  typedef enum logic [1:0] {
    K_SEL,
    K_WADDR,
    K_DATA
  } byte_kind_e;

endpackage

// File: rtl/ee2w_line_mon.sv
module ee2w_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sr, sda_sr;
  logic          scl_p, sda_p;

  // synchroniser chain plus one history stage, idle bus reads high
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[LAST-1:0], scl_in};
      sda_sr <= {sda_sr[LAST-1:0], sda_in};
      scl_p  <= scl_sr[LAST];
      sda_p  <= sda_sr[LAST];
    end
  end

  assign scl_lvl   = scl_sr[LAST];
  assign sda_lvl   = sda_sr[LAST];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/ee2w_addr_ctr.sv
module ee2w_addr_ctr #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [PAGE_W-1:0] PG_ONE   = 1;
  localparam logic [ADDR_W-1:0] FULL_ONE = 1;

  logic [ADDR_W-1:0] addr_q, addr_n;

  always_comb begin
    addr_n = addr_q;
    if (load) begin
      addr_n = load_val;
    end else if (inc_page) begin
      addr_n[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + PG_ONE;
    end else if (inc_full) begin
      addr_n = addr_q + FULL_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_n;
  end

  assign addr = addr_q;

  AST_PAGE_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_ni)
    (inc_page && !load) |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]))); // R3

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 7,
  parameter int         PAGE_W      = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              wp_in,
  input  logic              busy_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);

  localparam logic [3:0] BITS_FULL = 4'd8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  ee2w_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  logic              ctr_load, ctr_pg, ctr_full;
  logic [ADDR_W-1:0] ctr_addr;
  logic [7:0]        rx_q, rx_n;

  ee2w_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .load    (ctr_load),
    .load_val(rx_q[ADDR_W-1:0]),
    .inc_page(ctr_pg),
    .inc_full(ctr_full),
    .addr    (ctr_addr)
  );

  bus_st_e           st_q, st_n;
  byte_kind_e        kind_q, kind_n;
  logic [3:0]        bit_q, bit_n;
  logic [7:0]        tx_q, tx_n;
  logic              rw_q, rw_n, pend_q, pend_n, more_q, more_n;
  logic              oe_q, oe_n, ld_q, ld_n;
  logic              wstb_q, wstb_n, commit_q, commit_n, rreq_q, rreq_n;
  logic [ADDR_W-1:0] waddr_q, waddr_n, raddr_q, raddr_n;
  logic [7:0]        wdata_q, wdata_n;
  logic              sel_hit;

  assign sel_hit = (rx_q[7:1] == DEV_ADDR);

  always_comb begin
    st_n     = st_q;
    kind_n   = kind_q;
    bit_n    = bit_q;
    rx_n     = rx_q;
    rw_n     = rw_q;
    pend_n   = pend_q;
    more_n   = more_q;
    oe_n     = oe_q;
    ld_n     = rreq_q;
    tx_n     = ld_q ? rd_data : tx_q;
    wstb_n   = 1'b0;
    waddr_n  = waddr_q;
    wdata_n  = wdata_q;
    commit_n = 1'b0;
    rreq_n   = 1'b0;
    raddr_n  = raddr_q;
    ctr_load = 1'b0;
    ctr_pg   = 1'b0;
    ctr_full = 1'b0;

    if (stop_det) begin
      st_n     = ST_IDLE;
      oe_n     = 1'b0;
      commit_n = pend_q;
      pend_n   = 1'b0;
    end else if (start_det) begin
      st_n   = ST_RX;
      kind_n = K_SEL;
      bit_n  = '0;
      oe_n   = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            rx_n  = {rx_q[6:0], sda_lvl};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == BITS_FULL) begin
            bit_n = '0;
            unique case (kind_q)
              K_SEL: begin
                if (sel_hit && !busy_in) begin
                  rw_n = rx_q[0];
                  oe_n = 1'b1;
                  st_n = ST_ACK;
                  if (rx_q[0]) begin
                    rreq_n   = 1'b1;
                    raddr_n  = ctr_addr;
                    ctr_full = 1'b1;
                  end
                end else begin
                  st_n = ST_IDLE;
                end
              end
              K_WADDR: begin
                oe_n     = 1'b1;
                st_n     = ST_ACK;
                ctr_load = 1'b1;
              end
              default: begin
                if (wp_in) begin
                  st_n = ST_IDLE;
                end else begin
                  oe_n    = 1'b1;
                  st_n    = ST_ACK;
                  wstb_n  = 1'b1;
                  waddr_n = ctr_addr;
                  wdata_n = rx_q;
                  ctr_pg  = 1'b1;
                  pend_n  = 1'b1;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (rw_q) begin
              st_n = ST_TX;
              oe_n = ~tx_q[7];
            end else begin
              st_n   = ST_RX;
              oe_n   = 1'b0;
              kind_n = (kind_q == K_SEL) ? K_WADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_n = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == BITS_FULL) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              oe_n = ~tx_q[3'd7 - bit_q[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more_n = ~sda_lvl;
            if (!sda_lvl) begin
              rreq_n   = 1'b1;
              raddr_n  = ctr_addr;
              ctr_full = 1'b1;
            end
          end else if (scl_fall) begin
            if (more_q) begin
              st_n  = ST_TX;
              bit_n = '0;
              oe_n  = ~tx_q[7];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      kind_q   <= K_SEL;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      pend_q   <= 1'b0;
      more_q   <= 1'b0;
      oe_q     <= 1'b0;
      ld_q     <= 1'b0;
      wstb_q   <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      commit_q <= 1'b0;
      rreq_q   <= 1'b0;
      raddr_q  <= '0;
    end else begin
      st_q     <= st_n;
      kind_q   <= kind_n;
      bit_q    <= bit_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      rw_q     <= rw_n;
      pend_q   <= pend_n;
      more_q   <= more_n;
      oe_q     <= oe_n;
      ld_q     <= ld_n;
      wstb_q   <= wstb_n;
      waddr_q  <= waddr_n;
      wdata_q  <= wdata_n;
      commit_q <= commit_n;
      rreq_q   <= rreq_n;
      raddr_q  <= raddr_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_stb  = wstb_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign commit  = commit_q;
  assign rd_req  = rreq_q;
  assign rd_addr = raddr_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_lvl); // R10

  AST_SEL_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_ACK && kind_q == K_SEL && $rose(oe_q)) |-> !$past(busy_in)); // R5

  AST_NO_STB_PROTECTED: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_stb |-> !$past(wp_in)); // R6

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |=> !commit); // R4

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |-> $past(stop_det)); // R4

endmodule

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;

  localparam int Q    = 8;
  localparam int BUSY = 400;

  logic       clk = 1'b0;
  logic       rst_n, m_scl, m_sda, wp, busy;
  logic [7:0] rd_data;
  logic       sda_oe, wr_stb, commit, rd_req;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  wire        sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  ee2w_slave u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (m_scl),
    .sda_in (sda_bus),
    .sda_oe (sda_oe),
    .wp_in  (wp),
    .busy_in(busy),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .commit (commit),
    .rd_req (rd_req),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // page buffer and memory model
  logic [7:0] mem   [128];
  logic [7:0] stage [128];
  logic       stv   [128];
  logic [6:0] log_a [16];
  logic [7:0] log_d [16];
  int         log_n, n_commit, busy_cnt, oe_viol;
  logic       oe_p;

  assign busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) begin
        mem[i]   <= 8'(i) ^ 8'h5A;
        stv[i]   <= 1'b0;
        stage[i] <= 8'h00;
      end
      log_n    <= 0;
      n_commit <= 0;
      busy_cnt <= 0;
      rd_data  <= 8'h00;
    end else begin
      if (wr_stb) begin
        stage[wr_addr] <= wr_data;
        stv[wr_addr]   <= 1'b1;
        log_a[log_n[3:0]] <= wr_addr;
        log_d[log_n[3:0]] <= wr_data;
        log_n <= log_n + 1;
      end
      if (commit) begin
        for (int i = 0; i < 128; i++) begin
          if (stv[i]) mem[i] <= stage[i];
          stv[i] <= 1'b0;
        end
        busy_cnt <= BUSY;
        n_commit <= n_commit + 1;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
      if (rd_req) rd_data <= mem[rd_addr];
    end
  end

  // R10: watch for SDA enable changes while SCL is high
  always @(posedge clk) begin
    if (!rst_n) begin
      oe_p    <= 1'b0;
      oe_viol <= 0;
    end else begin
      oe_p <= sda_oe;
      if (sda_oe != oe_p && m_scl) oe_viol <= oe_viol + 1;
    end
  end

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bstop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = (sda_bus == 1'b0);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      m_scl = 1'b0; tick(Q);
    end
    m_sda = ~mack; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
    chk(wr_stb == 1'b0, "R1 wr_stb after reset", int'(wr_stb), 0);
    chk(commit == 1'b0, "R1 commit after reset", int'(commit), 0);
    chk(rd_req == 1'b0, "R1 rd_req after reset", int'(rd_req), 0);
  endtask

  task automatic t_page_write;
    bit a;
    int c0, l0;
    logic [7:0] dat [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    logic [6:0] adr [5] = '{7'h0D, 7'h0E, 7'h0F, 7'h08, 7'h09};
    c0 = n_commit;
    l0 = log_n;
    bstart;
    wbyte(8'hA0, a); chk(a, "R2 select ack", int'(a), 1);
    wbyte(8'h0D, a); chk(a, "R3 word address ack", int'(a), 1);
    for (int k = 0; k < 5; k++) begin
      wbyte(dat[k], a); chk(a, "R3 data ack", int'(a), 1);
    end
    bstop;
    tick(4);
    chk(n_commit == c0 + 1, "R4 one commit after stop", n_commit - c0, 1);
    chk(log_n == l0 + 5, "R3 strobe count", log_n - l0, 5);
    for (int k = 0; k < 5; k++) begin
      chk(log_a[(l0 + k) % 16] == adr[k], "R3 page-wrapped address",
          int'(log_a[(l0 + k) % 16]), int'(adr[k]));
      chk(log_d[(l0 + k) % 16] == dat[k], "R3 strobed data",
          int'(log_d[(l0 + k) % 16]), int'(dat[k]));
    end
  endtask

  task automatic t_poll;
    bit a;
    int c0;
    // start polling right after the stop that raised commit
    bstart;
    wbyte(8'hA0, a); chk(!a, "R5 select ignored while busy", int'(a), 0);
    bstop;
    while (busy) tick(1);
    tick(4);
    c0 = n_commit;
    bstart;
    wbyte(8'hA0, a); chk(a, "R5 select acked after busy", int'(a), 1);
    bstop;
    tick(4);
    chk(n_commit == c0, "R4 no commit without data", n_commit - c0, 0);
  endtask

  task automatic rand_read(input logic [6:0] adr, input logic [7:0] e0, input logic [7:0] e1,
                           input string tag);
    bit a;
    logic [7:0] b;
    bstart;
    wbyte(8'hA0, a); chk(a, "R9 select ack", int'(a), 1);
    wbyte({1'b0, adr}, a); chk(a, "R9 address ack", int'(a), 1);
    bstart;
    wbyte(8'hA1, a); chk(a, "R9 read select after repeated start", int'(a), 1);
    rbyte(1'b1, b); chk(b == e0, {tag, " first byte"}, int'(b), int'(e0));
    rbyte(1'b0, b); chk(b == e1, {tag, " next byte"}, int'(b), int'(e1));
  endtask

  task automatic t_random_read;
    rand_read(7'h0D, 8'h11, 8'h22, "R9 random read");
    bstop;
  endtask

  task automatic t_current_read;
    bit a;
    logic [7:0] b;
    bstart;
    wbyte(8'hA1, a); chk(a, "R7 current read select", int'(a), 1);
    rbyte(1'b0, b); chk(b == 8'h33, "R7 current address read", int'(b), 8'h33);
    bstop;
  endtask

  task automatic t_wrap_nack;
    bit a;
    rand_read(7'h7F, 8'h25, 8'h5A, "R7 rollover read");
    // master NACKed; no START, the controller must stay quiet
    wbyte(8'hA0, a); chk(!a, "R8 idle after master nack", int'(a), 0);
    chk(sda_oe == 1'b0, "R8 sda released", int'(sda_oe), 0);
    bstop;
  endtask

  task automatic t_wrong_dev;
    bit a;
    bstart;
    wbyte(8'hB0, a); chk(!a, "R2 foreign select", int'(a), 0);
    wbyte(8'h00, a); chk(!a, "R2 bytes ignored after foreign select", int'(a), 0);
    bstop;
  endtask

  task automatic t_wp;
    bit a;
    int c0, l0;
    logic [7:0] b;
    c0 = n_commit;
    l0 = log_n;
    wp = 1'b1;
    bstart;
    wbyte(8'hA0, a); chk(a, "R6 select ack under protect", int'(a), 1);
    wbyte(8'h20, a); chk(a, "R6 address ack under protect", int'(a), 1);
    wbyte(8'h99, a); chk(!a, "R6 data refused", int'(a), 0);
    bstop;
    tick(4);
    chk(log_n == l0, "R6 no strobe", log_n - l0, 0);
    chk(n_commit == c0, "R6 no commit", n_commit - c0, 0);
    wp = 1'b0;
    bstart;
    wbyte(8'hA0, a);
    wbyte(8'h20, a);
    bstart;
    wbyte(8'hA1, a);
    rbyte(1'b0, b); chk(b == 8'h7A, "R6 memory unchanged", int'(b), 8'h7A);
    bstop;
  endtask

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    wp    = 1'b0;
    tick(5);
    t_reset;
    rst_n = 1'b1;
    tick(5);
    t_page_write;
    t_poll;
    t_random_read;
    t_current_read;
    t_wrap_nack;
    t_wrong_dev;
    t_wp;
    chk(oe_viol == 0, "R10 sda changes only with scl low", oe_viol, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule